// File: doc/BRIEF.md
# Block Memory Copy and Search Engine

This block is a small sequential engine that moves or scans a run of bytes in a 16-bit address space without help from a processor. Software-visible setup is not part of the block. A parent drives a source pointer, a destination pointer, a byte count, a compare byte and three control bits on its configuration inputs, then pulses `start`. The engine samples those inputs once, on the start cycle. From then on it works alone through a single synchronous memory port. That port has an address, a write enable, write data, and read data that returns one cycle after the address is presented.

Copy mode takes the byte at the source pointer and stores it at the destination pointer. Search mode compares the byte at the source pointer with the compare byte. Either way, each step moves the pointers up or down by one and lowers the count by one, all in the same clock edge. In single mode the engine performs one step. In repeat mode a copy runs until the count is exhausted, and a search runs until the count is exhausted or the first equal byte is found, whichever comes first. After every step the updated pointers and count are visible on the outputs. A one-cycle `done` pulse marks the end of the operation.

Top module: `blk_xfer_engine`

## Requirements
- R1: A copy step takes two cycles. In the first cycle `mem_addr` carries the source pointer with `mem_we` low. In the second, `mem_we` is high, `mem_addr` carries the destination pointer and `mem_wdata` carries the byte just read. Overlapping regions are copied one byte at a time in step order.
- R2: `cfg_dir` = 0 selects incrementing and `cfg_dir` = 1 selects decrementing. Each copy step moves both pointers by one in the selected direction. Every step lowers the count by exactly one. Pointers wrap modulo 65536.
- R3: A search step takes two cycles: a read of the source pointer, then a compare of the returned byte with the compare byte. The step moves only the source pointer by direction, leaves the destination pointer unchanged and lowers the count by one.
- R4: With `cfg_repeat` = 1 and `cfg_mode` = 0 (copy), steps continue until the count reaches zero.
- R5: With `cfg_repeat` = 1 and `cfg_mode` = 1 (search), steps stop after the first step whose byte equals the compare byte, or when the count reaches zero. `match` is cleared on start and is set only by a search step whose byte equals the compare byte.
- R6: With `cfg_repeat` = 0 the engine performs exactly one step, whatever the count.
- R7: A starting count of zero means 65536 steps. A single step from zero leaves the count at 0xFFFF.
- R8: After reset the pointers and count are zero, and `busy`, `done`, `match` and `count_nz` are low. `count_nz` is high exactly when the count output is nonzero.
- R9: A `start` pulse while `busy` is high is ignored. The running operation's configuration, results and memory traffic are unaffected.
- R10: `done` is high for exactly one cycle, in the cycle after the last step's second cycle, with `busy` already low. An operation of N steps raises `done` 2N+1 cycles after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled only when idle) |
| cfg_src | input | 16 | Initial source pointer |
| cfg_dst | input | 16 | Initial destination pointer |
| cfg_count | input | 16 | Step count (0 means 65536) |
| cfg_key | input | 8 | Compare byte for search |
| cfg_dir | input | 1 | 0 increment, 1 decrement |
| cfg_repeat | input | 1 | 0 single step, 1 repeat |
| cfg_mode | input | 1 | 0 copy, 1 search |
| mem_addr | output | 16 | Memory address |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable |
| src_ptr | output | 16 | Current source pointer |
| dst_ptr | output | 16 | Current destination pointer |
| count | output | 16 | Current count |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| match | output | 1 | Last search step found an equal byte |
| count_nz | output | 1 | Count is nonzero |

## Verification
The embedded properties watch, on every cycle, the per-step arithmetic: the count drops by one, pointers move by one in the chosen direction, and a search leaves the destination alone. They also watch the fetch-then-act pairing, the width of the `done` pulse, the end conditions of both repeat modes, and that a busy-time start disturbs nothing. Only the bench's scenarios can show that the right bytes land in memory for overlapping and wrapping regions, the exact step at which a search stops, and the 65536-step meaning of a zero count. Those come from a sweep over direction, repeat, mode, length, overlap and match position, compared with an arithmetic model.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

  // Sequencer phases: idle, address phase of the read, action phase
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_ACT   = 2'd2
  } xfer_state_e;

  // Operation kind latched at start
  typedef enum logic {
    MODE_COPY   = 1'b0,
    MODE_SEARCH = 1'b1
  } xfer_mode_e;

endpackage

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        fin,
  output xfer_state_e state_q,
  output logic        load_evt,
  output logic        fetch_evt,
  output logic        step_evt,
  output logic        busy,
  output logic        done_q
);

  xfer_state_e state_d;

  always_comb begin
    load_evt  = start && (state_q == ST_IDLE);
    fetch_evt = (state_q == ST_FETCH);
    step_evt  = (state_q == ST_ACT);
    busy      = (state_q != ST_IDLE);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_FETCH;
      ST_FETCH: state_d = ST_ACT;
      ST_ACT:   state_d = fin ? ST_IDLE : ST_FETCH;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= step_evt && fin;
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy);

  // R1
  fetch_then_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_evt |=> step_evt);

endmodule

// File: rtl/blk_xfer_regs.sv
module blk_xfer_regs
  import blk_xfer_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          busy,
  input  logic          load_evt,
  input  logic          step_evt,
  input  logic          hit_evt,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_count,
  input  logic [DW-1:0] cfg_key,
  input  logic          cfg_dir,
  input  logic          cfg_repeat,
  input  xfer_mode_e    cfg_mode,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q,
  output logic [DW-1:0] key_q,
  output logic          dir_q,
  output logic          rep_q,
  output xfer_mode_e    mode_q,
  output logic          match_q
);

  localparam logic [AW-1:0] A_ONE = AW'(1);
  localparam logic [CW-1:0] C_ONE = CW'(1);

  // Pointer arithmetic, modulo 2**AW
  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p, input logic dec);
    return dec ? (p - A_ONE) : (p + A_ONE);
  endfunction

  // Count arithmetic, modulo 2**CW (zero start wraps to all ones)
  function automatic logic [CW-1:0] cnt_next(input logic [CW-1:0] c);
    return c - C_ONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      key_q   <= '0;
      dir_q   <= 1'b0;
      rep_q   <= 1'b0;
      mode_q  <= MODE_COPY;
      match_q <= 1'b0;
    end else if (load_evt) begin
      src_q   <= cfg_src;
      dst_q   <= cfg_dst;
      cnt_q   <= cfg_count;
      key_q   <= cfg_key;
      dir_q   <= cfg_dir;
      rep_q   <= cfg_repeat;
      mode_q  <= cfg_mode;
      match_q <= 1'b0;
    end else if (step_evt) begin
      src_q   <= ptr_next(src_q, dir_q);
      if (mode_q == MODE_COPY) dst_q <= ptr_next(dst_q, dir_q);
      cnt_q   <= cnt_next(cnt_q);
      match_q <= hit_evt;
    end
  end

  // R2
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (($past(cnt_q) - cnt_q) == C_ONE));

  // R2
  src_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !dir_q) |=> ((src_q - $past(src_q)) == A_ONE));

  // R2
  src_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && dir_q) |=> (($past(src_q) - src_q) == A_ONE));

  // R3
  search_dst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && mode_q == MODE_SEARCH) |=> $stable(dst_q));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !step_evt) |=> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q) && $stable(mode_q)));

endmodule

// File: rtl/blk_xfer_engine.sv
module blk_xfer_engine
  import blk_xfer_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_count,
  input  logic [DW-1:0] cfg_key,
  input  logic          cfg_dir,
  input  logic          cfg_repeat,
  input  logic          cfg_mode,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_ptr,
  output logic [CW-1:0] count,
  output logic          busy,
  output logic          done,
  output logic          match,
  output logic          count_nz
);

  localparam logic [CW-1:0] C_ONE = CW'(1);

  xfer_state_e   state_q;
  logic          load_evt, fetch_evt, step_evt, fin, hit_evt, last_cnt;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] key_q;
  logic          dir_q, rep_q, match_q;
  xfer_mode_e    mode_q;

  blk_xfer_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .fin       (fin),
    .state_q   (state_q),
    .load_evt  (load_evt),
    .fetch_evt (fetch_evt),
    .step_evt  (step_evt),
    .busy      (busy),
    .done_q    (done)
  );

  blk_xfer_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .load_evt   (load_evt),
    .step_evt   (step_evt),
    .hit_evt    (hit_evt),
    .cfg_src    (cfg_src),
    .cfg_dst    (cfg_dst),
    .cfg_count  (cfg_count),
    .cfg_key    (cfg_key),
    .cfg_dir    (cfg_dir),
    .cfg_repeat (cfg_repeat),
    .cfg_mode   (xfer_mode_e'(cfg_mode)),
    .src_q      (src_q),
    .dst_q      (dst_q),
    .cnt_q      (cnt_q),
    .key_q      (key_q),
    .dir_q      (dir_q),
    .rep_q      (rep_q),
    .mode_q     (mode_q),
    .match_q    (match_q)
  );

  // Memory port: source during fetch and search compare, destination on copy write
  always_comb begin
    mem_addr  = (step_evt && mode_q == MODE_COPY) ? dst_q : src_q;
    mem_we    = step_evt && (mode_q == MODE_COPY);
    mem_wdata = mem_rdata;
  end

  // Step outcome and termination
  always_comb begin
    hit_evt  = step_evt && (mode_q == MODE_SEARCH) && (mem_rdata == key_q);
    last_cnt = (cnt_q == C_ONE);
    fin      = !rep_q || last_cnt || hit_evt;
  end

  assign src_ptr  = src_q;
  assign dst_ptr  = dst_q;
  assign count    = cnt_q;
  assign match    = match_q;
  assign count_nz = |cnt_q;

  // R4
  rep_copy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rep_q && mode_q == MODE_COPY) |-> (count == '0));

  // R5
  rep_search_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rep_q && mode_q == MODE_SEARCH) |-> ((count == '0) || match));

  // R5
  match_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match) |-> ($past(hit_evt) && $past(mode_q) == MODE_SEARCH));

  // R1
  write_only_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(fetch_evt) && busy));

endmodule

// File: tb/blk_xfer_engine_bench.sv
`timescale 1ns/1ps
module blk_xfer_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] cfg_src = '0, cfg_dst = '0, cfg_count = '0;
  logic [7:0]  cfg_key = '0;
  logic        cfg_dir = 1'b0, cfg_repeat = 1'b0, cfg_mode = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [15:0] src_ptr, dst_ptr, count;
  logic        busy, done, match, count_nz;

  int n_chk = 0;
  int n_err = 0;

  logic [7:0] mem [0:1023];
  logic [7:0] sh  [0:1023];

  always #4 clk = ~clk;

  blk_xfer_engine u_blk_xfer_engine (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_count(cfg_count), .cfg_key(cfg_key),
    .cfg_dir(cfg_dir), .cfg_repeat(cfg_repeat), .cfg_mode(cfg_mode),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .src_ptr(src_ptr), .dst_ptr(dst_ptr), .count(count),
    .busy(busy), .done(done), .match(match), .count_nz(count_nz)
  );

  // Bench memory: one-cycle read latency, 1 KiB aliased over the 64 KiB space
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:0]];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 1024; i++) begin
      logic [7:0] v;
      v = 8'((i * 29 + seed * 7) & 255);
      if (v == 8'hA5) v = 8'h3C;
      mem[i] = v;
      sh[i]  = v;
    end
  endtask

  function automatic logic [15:0] stp(input logic [15:0] p, input logic dec);
    return dec ? p + 16'hFFFF : p + 16'h0001;
  endfunction

  task automatic run_op(input logic [15:0] s, input logic [15:0] d, input logic [15:0] n,
                        input logic [7:0] k, input logic dr, input logic rp,
                        input logic md, input bit inject);
    logic [15:0] es, ed, ec;
    logic        em, hit;
    int          steps, cyc, mism;
    bit          fin;
    string       rq;
    es = s; ed = d; ec = n; em = 1'b0; steps = 0; fin = 0;
    while (!fin) begin
      hit = 1'b0;
      if (!md) begin
        sh[ed[9:0]] = sh[es[9:0]];
        ed = stp(ed, dr);
      end else begin
        hit = (sh[es[9:0]] == k);
      end
      es = stp(es, dr);
      ec = ec - 16'd1;
      steps++;
      em = md && hit;
      if (!rp || ec == 16'd0 || hit) fin = 1;
    end
    rq = !rp ? "R6" : (md ? "R5" : "R4");

    @(negedge clk);
    cfg_src = s; cfg_dst = d; cfg_count = n; cfg_key = k;
    cfg_dir = dr; cfg_repeat = rp; cfg_mode = md; start = 1'b1;
    cyc = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) start = 1'b0;
      if (inject && cyc == 3) begin
        start = 1'b1; cfg_src = ~s; cfg_count = 16'd1; cfg_mode = ~md; cfg_dst = ~d;
      end
      if (inject && cyc == 4) start = 1'b0;
      if (done) break;
      if (cyc > 150000) begin
        chk(0, rq, "watchdog", cyc, 0);
        break;
      end
    end
    chk(cyc == 2 * steps + 1, "R10", "done cycle", cyc, 2 * steps + 1);
    chk(src_ptr == es, "R2", "src_ptr", src_ptr, es);
    chk(dst_ptr == ed, md ? "R3" : "R2", "dst_ptr", dst_ptr, ed);
    chk(count == ec, rq, "count", count, ec);
    chk(match == em, "R5", "match", match, em);
    chk(count_nz == (ec != 0), "R8", "count_nz", count_nz, ec != 0);
    chk(!busy, "R10", "busy at done", busy, 0);
    @(negedge clk);
    chk(!done, "R10", "done width", done, 0);
    mism = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== sh[i]) mism++;
    chk(mism == 0, md ? "R3" : "R1", "memory mismatches", mism, 0);
  endtask

  initial begin
    #1_500_000;
    chk(0, "R10", "global watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    fill(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(src_ptr == 0 && dst_ptr == 0 && count == 0, "R8", "reset regs", {src_ptr, dst_ptr}, 0);
    chk(!busy && !done && !match && !count_nz, "R8", "reset flags",
        {busy, done, match, count_nz}, 0);

    // Sweep copy: R1 R2 R4 R6 with wrap and overlap
    for (int dr = 0; dr < 2; dr++)
      for (int rp = 0; rp < 2; rp++)
        for (int n = 1; n <= 4; n++)
          for (int ov = 0; ov < 2; ov++) begin
            logic [15:0] s, d;
            s = dr[0] ? 16'h0001 : 16'hFFFE;
            d = ov[0] ? (dr[0] ? s - 16'd2 : s + 16'd2) : (s ^ 16'h0200);
            fill(n + ov);
            run_op(s, d, 16'(n), 8'h00, dr[0], rp[0], 1'b0, 0);
          end

    // Sweep search: R3 R5 R6 over match positions
    for (int dr = 0; dr < 2; dr++)
      for (int rp = 0; rp < 2; rp++)
        for (int n = 1; n <= 4; n++)
          for (int kp = 0; kp < 3; kp++) begin
            logic [15:0] s, a;
            logic [7:0]  key;
            int          pos;
            s = dr[0] ? 16'h0001 : 16'hFFFE;
            fill(n * 3 + kp);
            pos = (kp == 0) ? 0 : ((kp == 1) ? n / 2 : n);
            a = dr[0] ? s - 16'(pos) : s + 16'(pos);
            key = (pos == n) ? 8'hA5 : mem[a[9:0]];
            run_op(s, 16'h1234, 16'(n), key, dr[0], rp[0], 1'b1, 0);
          end

    // R7: single copy step from zero count leaves 0xFFFF
    fill(11);
    run_op(16'h0020, 16'h0300, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 0);
    chk(count == 16'hFFFF && count_nz, "R7", "single step from zero", count, 16'hFFFF);

    // R7: repeat search from zero count runs past the zero boundary
    fill(13);
    mem[10'h357] = 8'hA5;
    sh[10'h357]  = 8'hA5;
    run_op(16'h0100, 16'h0000, 16'h0000, 8'hA5, 1'b0, 1'b1, 1'b1, 0);
    chk(count == 16'hFDA8 && match, "R7", "zero count search", count, 16'hFDA8);

    // R9: start while busy is ignored
    fill(17);
    run_op(16'h0010, 16'h0210, 16'd6, 8'h00, 1'b0, 1'b1, 1'b0, 1);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule